// File: doc/BRIEF.md
# Non-Blocking Data Cache Miss Tracker

This block keeps a small table of data-cache line fills that are still in flight, so the load/store unit can go on issuing accesses while earlier misses are unresolved. A miss names a cache line, the first word it needs, how many further sequential words it wants, and the write-back or write-through attribute from its translation. A miss to a line that is not yet tracked takes a free table slot, and the slot raises one line-fill request toward memory. A miss to a line that is already tracked joins that slot and does not take a new one.

Memory answers each fill with four 64-bit beats, which may arrive in any order. Each beat carries its index and the slot number that was sent with the fill request. Waiting words go to the core one per cycle as soon as their beat is present. A word whose beat is on the beat port in the current cycle is passed straight through, so the core does not wait for the whole line. When the table is full, a miss to a new line is refused until a slot frees.

Top module: `miss_tracker`

## Requirements
- R1: At most three distinct lines are tracked at once. `reqReady` is low exactly when all three slots hold lines and `reqLine` matches none of them. A miss is taken in a cycle where `reqValid` and `reqReady` are both high.
- R2: A miss to an untracked line takes the lowest-numbered free slot. From the next cycle, that slot offers one fill request carrying its slot number, its line and its attribute. When several slots have no fill issued, the lowest-numbered one is offered. A slot issues its fill exactly once, at the cycle where `fillReqReady` is high.
- R3: A miss asks for the words `reqWord` up to `min(reqWord + reqSpan, 7)` of its line. Each such word is driven once on the word port with the slot number, the word index and the word data. A word that several misses wait on at the same time is driven once.
- R4: A beat with index k carries word 2k in bits 31:0 and word 2k+1 in bits 63:32. A waiting word may be driven in the very cycle its beat is on the beat port.
- R5: A miss whose line is already tracked takes no slot. Any of its words whose beat has already arrived, or is arriving now, can be driven in the same cycle as the miss.
- R6: At most one word is driven per cycle. Among all words that are ready, the lowest slot number wins, and within that slot the lowest word index wins.
- R7: A slot keeps the attribute of the miss that allocated it. That attribute goes out with the fill request and with every word the slot delivers. The attribute of a joining miss is ignored.
- R8: A slot becomes free in the cycle after the one in which it holds all four beats and has no word left waiting. It can be allocated again from that cycle on.
- R9: After reset no slot is in use, `reqReady` is high, and neither `fillReqValid` nor `wordValid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A miss is presented |
| reqLine | input | LINE_W | Line address of the miss |
| reqWord | input | 3 | First word wanted within the line |
| reqSpan | input | 3 | Number of further sequential words wanted |
| reqWb | input | 1 | Attribute of the miss: 1 write-back, 0 write-through |
| reqReady | output | 1 | The miss can be taken this cycle |
| fillReqValid | output | 1 | A fill request is offered |
| fillReqReady | input | 1 | Memory takes the offered fill request |
| fillReqId | output | 2 | Slot number of the fill |
| fillReqLine | output | LINE_W | Line to fetch |
| fillReqWb | output | 1 | Attribute stored in the slot |
| beatValid | input | 1 | A fill beat is present |
| beatId | input | 2 | Slot number the beat belongs to |
| beatIdx | input | 2 | Position of the beat within the line |
| beatData | input | 64 | Two words of the line, lower word in bits 31:0 |
| wordValid | output | 1 | A word is delivered to the core |
| wordId | output | 2 | Slot the word belongs to |
| wordIdx | output | 3 | Index of the word within the line |
| wordData | output | 32 | The word |
| wordWb | output | 1 | Attribute of the slot |

## Verification
A joining miss and an arriving beat can land in the same cycle as a fill handshake and the freeing of another slot. Word delivery can therefore draw at once on stored beats, the beat on the port and a mask that the current miss has just added. The bench provokes this with a small pool of line addresses, so joins, full-table stalls and reuse of freed slots happen often. It also returns beats in random order while misses keep arriving, and adds directed cases for straight-through delivery and for joining a line whose beat is already stored. Each cycle, a model built from the requirements predicts `reqReady`, the fill offer and the exact word, slot and attribute to be delivered, and compares them with the ports.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;
  localparam int ENTRIES    = 3;
  localparam int WORDS      = 8;
  localparam int BEAT_WORDS = 2;
  localparam int BEATS      = WORDS / BEAT_WORDS;
  localparam int WORD_W     = 32;
  localparam int BEAT_W     = WORD_W * BEAT_WORDS;
  localparam int ID_W       = $clog2(ENTRIES);
  localparam int WIDX_W     = $clog2(WORDS);
  localparam int BIDX_W     = $clog2(BEATS);

  // strobes from control to the line-buffer datapath
  typedef struct packed {
    logic              wrEn;
    logic [ID_W-1:0]   wrId;
    logic [BIDX_W-1:0] wrBeat;
    logic              rdEn;
    logic [ID_W-1:0]   rdId;
    logic [WIDX_W-1:0] rdWord;
    logic              rdBypass;
  } mt_strobe_t;
endpackage

// File: rtl/mt_data.sv
`timescale 1ns/1ps
module mt_data
  import mt_pkg::*;
(
  input  logic              clk,
  input  mt_strobe_t        strobe,
  input  logic [BEAT_W-1:0] beatData,
  output logic [WORD_W-1:0] wordData
);
  localparam int SLOTS = ENTRIES * BEATS;

  logic [BEAT_W-1:0] lineBuf [SLOTS];
  logic [BEAT_W-1:0] rdBeat;
  int                wrAddr;
  int                rdAddr;
  int                halfSel;

  always_comb begin
    wrAddr  = int'(strobe.wrId) * BEATS + int'(strobe.wrBeat);
    rdAddr  = int'(strobe.rdId) * BEATS + int'(strobe.rdWord) / BEAT_WORDS;
    halfSel = int'(strobe.rdWord) % BEAT_WORDS;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn && wrAddr < SLOTS) lineBuf[wrAddr] <= beatData;
  end

  always_comb begin
    rdBeat = '0;
    if (strobe.rdBypass)     rdBeat = beatData;
    else if (rdAddr < SLOTS) rdBeat = lineBuf[rdAddr];
    wordData = strobe.rdEn ? rdBeat[halfSel*WORD_W +: WORD_W] : '0;
  end
endmodule

// File: rtl/mt_ctrl.sv
`timescale 1ns/1ps
module mt_ctrl
  import mt_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [WIDX_W-1:0] reqWord,
  input  logic [WIDX_W-1:0] reqSpan,
  input  logic              reqWb,
  output logic              reqReady,
  output logic              fillReqValid,
  input  logic              fillReqReady,
  output logic [ID_W-1:0]   fillReqId,
  output logic [LINE_W-1:0] fillReqLine,
  output logic              fillReqWb,
  input  logic              beatValid,
  input  logic [ID_W-1:0]   beatId,
  input  logic [BIDX_W-1:0] beatIdx,
  output logic              wordValid,
  output logic [ID_W-1:0]   wordId,
  output logic [WIDX_W-1:0] wordIdx,
  output logic              wordWb,
  output mt_strobe_t        strobe
);
  // per-slot state
  logic [ENTRIES-1:0] vld, sent, wbAttr;
  logic [LINE_W-1:0]  lineTag [ENTRIES];
  logic [BEATS-1:0]   got     [ENTRIES];
  logic [WORDS-1:0]   pend    [ENTRIES];

  // lookup and allocation
  logic [WORDS-1:0] reqMask;
  logic             hit, anyFree, accept, doMerge, doAlloc;
  logic [ID_W-1:0]  matchId, allocId;

  always_comb begin
    for (int w = 0; w < WORDS; w++)
      reqMask[w] = (w >= int'(reqWord)) && (w <= int'(reqWord) + int'(reqSpan));
  end

  always_comb begin
    hit     = 1'b0;
    matchId = '0;
    allocId = '0;
    anyFree = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (vld[e] && lineTag[e] == reqLine) begin
        hit     = 1'b1;
        matchId = ID_W'(e);
      end
    end
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!vld[e]) begin
        anyFree = 1'b1;
        allocId = ID_W'(e);
      end
    end
  end

  assign reqReady = hit || anyFree;
  assign accept   = reqValid && reqReady;
  assign doMerge  = accept && hit;
  assign doAlloc  = accept && !hit;

  // word readiness
  logic [BEATS-1:0] arrive [ENTRIES];
  logic [BEATS-1:0] gotN   [ENTRIES];
  logic [WORDS-1:0] have   [ENTRIES];
  logic [WORDS-1:0] want   [ENTRIES];
  logic [WORDS-1:0] ready  [ENTRIES];

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      arrive[e] = '0;
      if (beatValid && beatId == ID_W'(e)) arrive[e][beatIdx] = 1'b1;
      gotN[e] = got[e] | arrive[e];
      for (int w = 0; w < WORDS; w++) have[e][w] = gotN[e][w / BEAT_WORDS];
      want[e]  = pend[e] | ((doMerge && matchId == ID_W'(e)) ? reqMask : '0);
      ready[e] = want[e] & have[e];
    end
  end

  // delivery pick: lowest slot, then lowest word
  logic              selFound;
  logic [ID_W-1:0]   selId;
  logic [WIDX_W-1:0] selWord;

  always_comb begin
    selFound = 1'b0;
    selId    = '0;
    selWord  = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      for (int w = WORDS - 1; w >= 0; w--) begin
        if (ready[e][w]) begin
          selFound = 1'b1;
          selId    = ID_W'(e);
          selWord  = WIDX_W'(w);
        end
      end
    end
  end

  logic [WORDS-1:0] pendN [ENTRIES];
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      pendN[e] = want[e];
      if (selFound && selId == ID_W'(e)) pendN[e][selWord] = 1'b0;
    end
  end

  assign wordValid = selFound;
  assign wordId    = selId;
  assign wordIdx   = selWord;
  assign wordWb    = wbAttr[selId];

  // fill issue
  logic [ENTRIES-1:0] fillCand;
  always_comb begin
    fillCand  = vld & ~sent;
    fillReqId = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (fillCand[e]) fillReqId = ID_W'(e);
  end
  assign fillReqValid = |fillCand;
  assign fillReqLine  = lineTag[fillReqId];
  assign fillReqWb    = wbAttr[fillReqId];

  // strobes to datapath
  always_comb begin
    strobe.wrEn     = beatValid;
    strobe.wrId     = beatId;
    strobe.wrBeat   = beatIdx;
    strobe.rdEn     = selFound;
    strobe.rdId     = selId;
    strobe.rdWord   = selWord;
    strobe.rdBypass = !got[selId][int'(selWord) / BEAT_WORDS];
  end

  // state update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld    <= '0;
      sent   <= '0;
      wbAttr <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        lineTag[e] <= '0;
        got[e]     <= '0;
        pend[e]    <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (doAlloc && allocId == ID_W'(e)) begin
          vld[e]     <= 1'b1;
          sent[e]    <= 1'b0;
          wbAttr[e]  <= reqWb;
          lineTag[e] <= reqLine;
          got[e]     <= '0;
          pend[e]    <= reqMask;
        end else if (vld[e]) begin
          got[e]  <= gotN[e];
          pend[e] <= pendN[e];
          if (fillReqValid && fillReqReady && fillReqId == ID_W'(e)) sent[e] <= 1'b1;
          if ((&gotN[e]) && pendN[e] == '0) vld[e] <= 1'b0;
        end
      end
    end
  end

  // checks guarding the control
  a_r2_fill_once: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid && fillReqReady |=> !(fillReqValid && fillReqId == $past(fillReqId)));

  a_r5_merge_no_growth: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && hit |=> $countones(vld) <= $past($countones(vld)));

  a_r3_word_from_live_slot: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> vld[wordId] && sent[wordId]);

  a_r4_word_beat_present: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && !beatValid |-> got[wordId][int'(wordIdx) / BEAT_WORDS]);

  a_r2_beat_after_fill: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> vld[beatId] && sent[beatId]);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slotChk
    a_r1_line_kept: assert property (@(posedge clk) disable iff (!rstN)
      vld[g] && $past(vld[g]) |-> $stable(lineTag[g]));
    a_r7_attr_kept: assert property (@(posedge clk) disable iff (!rstN)
      vld[g] && $past(vld[g]) |-> $stable(wbAttr[g]));
  end
endmodule

// File: rtl/miss_tracker.sv
`timescale 1ns/1ps
module miss_tracker
  import mt_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [WIDX_W-1:0] reqWord,
  input  logic [WIDX_W-1:0] reqSpan,
  input  logic              reqWb,
  output logic              reqReady,
  output logic              fillReqValid,
  input  logic              fillReqReady,
  output logic [ID_W-1:0]   fillReqId,
  output logic [LINE_W-1:0] fillReqLine,
  output logic              fillReqWb,
  input  logic              beatValid,
  input  logic [ID_W-1:0]   beatId,
  input  logic [BIDX_W-1:0] beatIdx,
  input  logic [BEAT_W-1:0] beatData,
  output logic              wordValid,
  output logic [ID_W-1:0]   wordId,
  output logic [WIDX_W-1:0] wordIdx,
  output logic [WORD_W-1:0] wordData,
  output logic              wordWb
);
  mt_strobe_t strobe;

  mt_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqLine(reqLine), .reqWord(reqWord), .reqSpan(reqSpan),
    .reqWb(reqWb), .reqReady(reqReady),
    .fillReqValid(fillReqValid), .fillReqReady(fillReqReady), .fillReqId(fillReqId),
    .fillReqLine(fillReqLine), .fillReqWb(fillReqWb),
    .beatValid(beatValid), .beatId(beatId), .beatIdx(beatIdx),
    .wordValid(wordValid), .wordId(wordId), .wordIdx(wordIdx), .wordWb(wordWb),
    .strobe(strobe)
  );

  mt_data u_data (
    .clk(clk), .strobe(strobe), .beatData(beatData), .wordData(wordData)
  );
endmodule

// File: tb/miss_tracker_bench.sv
`timescale 1ns/1ps
module miss_tracker_bench;
  localparam int LW = 26;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [LW-1:0] reqLine = '0;
  logic [2:0]    reqWord = '0, reqSpan = '0;
  logic          reqWb = 1'b0;
  logic          reqReady;
  logic          fillReqValid, fillReqWb;
  logic          fillReqReady = 1'b0;
  logic [1:0]    fillReqId;
  logic [LW-1:0] fillReqLine;
  logic          beatValid = 1'b0;
  logic [1:0]    beatId = '0, beatIdx = '0;
  logic [63:0]   beatData = '0;
  logic          wordValid, wordWb;
  logic [1:0]    wordId;
  logic [2:0]    wordIdx;
  logic [31:0]   wordData;

  always #2 clk = ~clk;

  miss_tracker #(.LINE_W(LW)) u_miss_tracker (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqLine(reqLine), .reqWord(reqWord), .reqSpan(reqSpan),
    .reqWb(reqWb), .reqReady(reqReady),
    .fillReqValid(fillReqValid), .fillReqReady(fillReqReady), .fillReqId(fillReqId),
    .fillReqLine(fillReqLine), .fillReqWb(fillReqWb),
    .beatValid(beatValid), .beatId(beatId), .beatIdx(beatIdx), .beatData(beatData),
    .wordValid(wordValid), .wordId(wordId), .wordIdx(wordIdx), .wordData(wordData),
    .wordWb(wordWb)
  );

  int  nChecks = 0, nFails = 0;
  bit  summaryDone = 0;

  // model of the slot table, built from the requirements
  bit       mVld [3], mSent [3], mWb [3];
  int       mLine [3];
  bit [3:0] mGot [3];
  bit [7:0] mPend [3];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    end
  endtask

  function automatic logic [31:0] dataOf(input int ln, input int w);
    return 32'(ln * 32'h9E3779B1) ^ 32'(w * 32'h01010101) ^ 32'hC0DE0000;
  endfunction

  function automatic bit [7:0] spanMask(input int wd, input int sp);
    bit [7:0] m = '0;
    for (int w = 0; w < 8; w++) m[w] = (w >= wd) && (w <= wd + sp);
    return m;
  endfunction

  // one cycle: drive, sample at the falling edge, advance the model
  task automatic step(input bit rv, input int ln, input int wd, input int sp, input bit wb,
                      input bit fr, input bit bv, input int bid, input int bix);
    int mi, fi, fe, se, sw;
    bit expRdy, acc;
    bit [7:0] rm;
    bit [7:0] want [3];
    bit [3:0] gn [3];
    @(posedge clk);
    #1;
    reqValid = rv; reqLine = LW'(ln); reqWord = 3'(wd); reqSpan = 3'(sp); reqWb = wb;
    fillReqReady = fr;
    beatValid = bv; beatId = 2'(bid); beatIdx = 2'(bix);
    beatData = bv ? {dataOf(mLine[bid], 2*bix+1), dataOf(mLine[bid], 2*bix)} : 64'h0;
    @(negedge clk);

    mi = -1; fi = -1; fe = -1; se = -1; sw = -1;
    for (int e = 0; e < 3; e++) if (mVld[e] && mLine[e] == ln) mi = e;
    for (int e = 2; e >= 0; e--) if (!mVld[e]) fi = e;
    expRdy = (mi >= 0) || (fi >= 0);
    chk(reqReady === expRdy, "R1", "reqReady", reqReady, expRdy);
    acc = rv && expRdy;
    rm  = spanMask(wd, sp);

    for (int e = 2; e >= 0; e--) if (mVld[e] && !mSent[e]) fe = e;
    chk(fillReqValid === (fe >= 0), "R2", "fillReqValid", fillReqValid, fe >= 0);
    if (fe >= 0 && fillReqValid === 1'b1) begin
      chk(fillReqId == 2'(fe), "R2", "fillReqId", fillReqId, fe);
      chk(fillReqLine == LW'(mLine[fe]), "R2", "fillReqLine", fillReqLine, mLine[fe]);
      chk(fillReqWb == mWb[fe], "R7", "fillReqWb", fillReqWb, mWb[fe]);
    end

    for (int e = 0; e < 3; e++) begin
      gn[e] = mGot[e];
      if (bv && bid == e) gn[e][bix] = 1'b1;
      want[e] = mPend[e] | ((acc && mi == e) ? rm : 8'h0);
    end
    for (int e = 2; e >= 0; e--)
      for (int w = 7; w >= 0; w--)
        if (mVld[e] && want[e][w] && gn[e][w/2]) begin se = e; sw = w; end
    chk(wordValid === (se >= 0), "R4 R5", "wordValid", wordValid, se >= 0);
    if (se >= 0 && wordValid === 1'b1) begin
      chk(wordId == 2'(se), "R6", "wordId", wordId, se);
      chk(wordIdx == 3'(sw), "R6", "wordIdx", wordIdx, sw);
      chk(wordData == dataOf(mLine[se], sw), "R3", "wordData", wordData, dataOf(mLine[se], sw));
      chk(wordWb == mWb[se], "R7", "wordWb", wordWb, mWb[se]);
    end

    if (fe >= 0 && fr) mSent[fe] = 1;
    for (int e = 0; e < 3; e++) begin
      if (acc && mi < 0 && fi == e) begin
        mVld[e] = 1; mSent[e] = 0; mWb[e] = wb; mLine[e] = ln; mGot[e] = '0; mPend[e] = rm;
      end else if (mVld[e]) begin
        if (se == e) want[e][sw] = 1'b0;
        mGot[e] = gn[e]; mPend[e] = want[e];
        if (&gn[e] && want[e] == 8'h0) mVld[e] = 0;   // R8 freeing
      end
    end
  endtask

  task automatic idle(input bit fr);
    step(0, 0, 0, 0, 0, fr, 0, 0, 0);
  endtask

  // pick a random outstanding beat, or none
  task automatic randBeat(output bit bv, output int bid, output int bix);
    int cid [12], cbx [12];
    int n = 0;
    for (int e = 0; e < 3; e++)
      for (int b = 0; b < 4; b++)
        if (mVld[e] && mSent[e] && !mGot[e][b]) begin cid[n] = e; cbx[n] = b; n++; end
    bv = 0; bid = 0; bix = 0;
    if (n > 0) begin
      int k = int'($urandom % 32'(n));
      bv = 1; bid = cid[k]; bix = cbx[k];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    bit bv;
    int bid, bix;
    void'($urandom(32'd20240611));
    for (int e = 0; e < 3; e++) begin
      mVld[e] = 0; mSent[e] = 0; mWb[e] = 0; mLine[e] = 0; mGot[e] = '0; mPend[e] = '0;
    end
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      chk(reqReady === 1'b1, "R9", "reqReady in reset", reqReady, 1);
      chk(fillReqValid === 1'b0, "R9", "fillReqValid in reset", fillReqValid, 0);
      chk(wordValid === 1'b0, "R9", "wordValid in reset", wordValid, 0);
    end
    @(posedge clk); #1 rstN = 1'b1;

    // directed: fill the table, fourth line stalls (R1), join keeps attribute (R7)
    step(1, 10, 3, 2, 1, 0, 0, 0, 0);
    step(1, 11, 0, 0, 0, 0, 0, 0, 0);
    step(1, 12, 7, 3, 1, 0, 0, 0, 0);
    step(1, 13, 1, 0, 0, 0, 0, 0, 0);   // R1 stall expected
    step(1, 11, 5, 0, 1, 0, 0, 0, 0);   // R5 join, R7 attribute ignored
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);    // R2 fills leave in slot order
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1, 2);    // R4 word 5 passed straight through
    step(1, 11, 4, 0, 1, 0, 0, 0, 0);   // R5 stored beat served at once
    step(1, 13, 0, 0, 0, 0, 1, 0, 1);   // R4 beat and stalled request together
    step(0, 0, 0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1, 1);
    step(1, 13, 2, 1, 1, 0, 1, 1, 3);   // R8 slot 1 frees after its last beat
    step(1, 13, 2, 1, 1, 1, 0, 0, 0);   // R8 reuse of the lowest free slot
    repeat (20) begin
      randBeat(bv, bid, bix);
      step(0, 0, 0, 0, 0, 1, bv, bid, bix);
    end

    // constrained random traffic over a small line pool
    for (int c = 0; c < 5000; c++) begin
      randBeat(bv, bid, bix);
      step(($urandom % 4) != 0, 100 + int'($urandom % 6), int'($urandom % 8),
           int'($urandom % 4), bit'($urandom % 2), ($urandom % 10) < 7,
           bv && (($urandom % 3) != 0), bid, bix);
    end

    // drain every slot
    for (int c = 0; c < 300; c++) begin
      randBeat(bv, bid, bix);
      step(0, 0, 0, 0, 0, 1, bv, bid, bix);
    end
    for (int e = 0; e < 3; e++) chk(!mVld[e], "R8", "slot still busy after drain", mVld[e], 0);
    idle(0);
    chk(reqReady === 1'b1 && fillReqValid === 1'b0, "R8", "idle after drain",
        {reqReady, fillReqValid}, 2'b10);
    summary();
    $finish;
  end
endmodule